// File: doc/BRIEF.md
# Byte-Level I2C Master with Event Status Codes

This block is an I2C bus master that software steers one bus event at a time. A small control word is changed only through two write strobes. One strobe ORs ones into the word and the other clears the bits marked with ones. An 8-bit data register holds the byte to send, or the byte just received. Each completed bus step (a START, an address byte, a data byte, a STOP, or a lost arbitration) loads a fixed 8-bit status code and raises an event flag. While that flag is up, the master holds SCL low and does nothing more on the bus.

Software reads the status code, loads the next byte or asks for a STOP, and then clears the event flag. The block then acts on the control bits as they stand at that moment. The first byte after a START is the 7-bit target address followed by a direction bit. A direction bit of 1 turns every later byte of that transfer into a received byte. SCL high and low times are set in system-clock cycles through two count inputs. The START hold time and the STOP setup time both equal the high count.

Top module: `i2cm_status_master`

## Requirements
- R1: After reset the control word reads 0x00 and the status reads 0xF8. Both bus lines are released (scl_oe=0, sda_oe=0).
- R2: A ones-bit in the set strobe's data sets a control bit. The enable bit is bit 6, start is bit 5, stop is bit 4 and ack-enable is bit 2. A ones-bit in the clear strobe's data clears enable (6), start (5), the event flag (3) or ack-enable (2). Zero bits have no effect. The set strobe cannot raise the event flag (bit 3), and the clear strobe cannot clear stop (bit 4).
- R3: When enable and start are set, the event flag is clear and both lines are high, the master pulls SDA low. After the START hold time it pulls SCL low, sets the event flag and loads status 0x08.
- R4: While the event flag is set, the master keeps SCL low and starts no bus activity.
- R5: The byte after a START is sent MSB first, and its bit 0 selects a read (1) or a write (0). The status then becomes 0x18 (write, ACK), 0x20 (write, NACK), 0x40 (read, ACK) or 0x48 (read, NACK).
- R6: In a START, SDA is low for exactly the high count before SCL falls. In a STOP, SCL is released for exactly the high count before SDA rises. SDA does not change while SCL is high inside a bit. A count of 0 acts as 1.
- R7: Clearing the event flag while stop is set produces a STOP. The hardware then clears stop, loads status 0xF8 and releases both lines.
- R8: A data byte in a write transfer ends with status 0x28 (ACK received) or 0x30 (NACK received).
- R9: In a read transfer, each data byte is placed in the data register. The master drives ACK in the ninth bit when ack-enable was set as the byte began, and NACK otherwise. The status becomes 0x50 or 0x58 to match.
- R10: If SDA reads low in a bit where the master is sending a 1, the master releases both lines, loads status 0x38, sets the event flag and goes idle.
- R11: Stop set while the master does not own the bus is cleared by hardware, with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| set_we | input | 1 | Set strobe for the control word |
| clr_we | input | 1 | Clear strobe for the control word |
| dat_we | input | 1 | Write strobe for the data register |
| wdata | input | 8 | Write data for all three strobes |
| hi_cnt | input | CW | SCL high time in clock cycles |
| lo_cnt | input | CW | SCL low time in clock cycles |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| ctl_q | output | 8 | Control word {0,en,start,stop,event,ack_en,0,0} |
| stat_q | output | 8 | Status code |
| dat_q | output | 8 | Data register |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that SCL follows only this master: no target stretches the clock, so SDA is the only line another device can pull. They also assume that software does not write the data register while a byte is on the wire. The stimulus keeps to both assumptions. The bench's target model drives SDA only during SCL low phases. The bench writes the data register and strobes only while the event flag holds the bus, or while the bus is idle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_HOLD, S_BLO, S_BHI, S_P1, S_P2, S_P3
  } state_t;

  localparam int B_EN  = 6;
  localparam int B_STA = 5;
  localparam int B_STO = 4;
  localparam int B_EVT = 3;
  localparam int B_AA  = 2;

  localparam logic [7:0] ST_START = 8'h08;
  localparam logic [7:0] ST_ARB   = 8'h38;
  localparam logic [7:0] ST_IDLE  = 8'hF8;

  // status after the ninth bit of a byte
  function automatic logic [7:0] byte_status(input logic addr_ph, input logic rd,
                                             input logic ack);
    if (addr_ph) return rd ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20);
    return rd ? (ack ? 8'h50 : 8'h58) : (ack ? 8'h28 : 8'h30);
  endfunction
endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] period,
  output logic          expire
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] eff;

  assign eff    = (period == '0) ? CW'(1) : period;
  assign expire = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart)      cnt <= eff - CW'(1);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  // R6
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt < eff || $past(period) != period));
endmodule

// File: rtl/i2cm_ctl_regs.sv
module i2cm_ctl_regs import i2cm_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_we,
  input  logic       clr_we,
  input  logic       dat_we,
  input  logic [7:0] wdata,
  input  logic       evt_raise,
  input  logic       stat_wr,
  input  logic [7:0] stat_code,
  input  logic       sto_done,
  input  logic       rx_wr,
  input  logic [7:0] rx_byte,
  output logic       en_q,
  output logic       sta_q,
  output logic       sto_q,
  output logic       evt_q,
  output logic       aa_q,
  output logic [7:0] ctl_q,
  output logic [7:0] stat_q,
  output logic [7:0] dat_q
);
  logic unused_bits;
  assign unused_bits = ^{wdata[7], wdata[1:0]};

  assign ctl_q = {1'b0, en_q, sta_q, sto_q, evt_q, aa_q, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0; evt_q <= 1'b0; aa_q <= 1'b0;
    end else begin
      if (set_we) begin
        if (wdata[B_EN])  en_q  <= 1'b1;
        if (wdata[B_STA]) sta_q <= 1'b1;
        if (wdata[B_STO]) sto_q <= 1'b1;
        if (wdata[B_AA])  aa_q  <= 1'b1;
      end
      if (clr_we) begin
        if (wdata[B_EN])  en_q  <= 1'b0;
        if (wdata[B_STA]) sta_q <= 1'b0;
        if (wdata[B_EVT]) evt_q <= 1'b0;
        if (wdata[B_AA])  aa_q  <= 1'b0;
      end
      if (evt_raise) evt_q <= 1'b1;
      if (sto_done)  sto_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= ST_IDLE;
      dat_q  <= 8'h00;
    end else begin
      if (stat_wr) stat_q <= stat_code;
      if (rx_wr)   dat_q  <= rx_byte;
      else if (dat_we) dat_q <= wdata;
    end
  end

  // R3
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_raise |=> evt_q);
  // R7
  sto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sto_done |=> !sto_q);
  // R2
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_we || clr_we) && wdata == 8'h00 && !evt_raise && !sto_done) |=> $stable(ctl_q));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_en,
  input  logic          ctl_sta,
  input  logic          ctl_sto,
  input  logic          ctl_evt,
  input  logic          ctl_aa,
  input  logic [7:0]    dat_q,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  input  logic          bus_free,
  input  logic          sda_i,
  input  logic          tmr_expire,
  output logic          tmr_restart,
  output logic [CW-1:0] tmr_period,
  output logic          evt_raise,
  output logic          stat_wr,
  output logic [7:0]    stat_code,
  output logic          sto_done,
  output logic          rx_wr,
  output logic [7:0]    rx_byte,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam logic [3:0] LAST_DATA = 4'd7;
  localparam logic [3:0] ACK_SLOT  = 4'd8;

  state_t     st, st_n;
  logic [3:0] idx, idx_n;
  logic [7:0] shift, sh_n;
  logic       sda_drv, sd_n, addr_ph, ap_n, rd_mode, rm_n, rx_now, rx_n, ack_drv, ak_n;
  logic       begin_rx, ack_seen, arb_lost;

  assign begin_rx = !addr_ph && rd_mode;
  assign ack_seen = rx_now ? ack_drv : !sda_i;
  assign arb_lost = (st == S_BHI) && tmr_expire && (idx < ACK_SLOT) &&
                    !rx_now && !sda_drv && !sda_i;
  assign rx_byte  = shift;

  assign scl_oe = (st == S_HOLD) || (st == S_BLO) || (st == S_P1);
  assign sda_oe = (st == S_START) || (st == S_P1) || (st == S_P2) ||
                  (((st == S_HOLD) || (st == S_BLO) || (st == S_BHI)) && sda_drv);

  always_comb begin
    st_n = st; idx_n = idx; sh_n = shift; sd_n = sda_drv;
    ap_n = addr_ph; rm_n = rd_mode; rx_n = rx_now; ak_n = ack_drv;
    tmr_restart = 1'b0; tmr_period = hi_cnt;
    evt_raise = 1'b0; stat_wr = 1'b0; stat_code = ST_IDLE;
    sto_done = 1'b0; rx_wr = 1'b0;
    case (st)
      S_IDLE: begin
        sd_n = 1'b0;
        if (ctl_sto) sto_done = 1'b1;
        else if (ctl_en && ctl_sta && !ctl_evt && bus_free) begin
          st_n = S_START; sd_n = 1'b1; tmr_restart = 1'b1;
        end
      end
      S_START: if (tmr_expire) begin
        st_n = S_HOLD; evt_raise = 1'b1; stat_wr = 1'b1; stat_code = ST_START;
        ap_n = 1'b1; rm_n = 1'b0;
      end
      S_HOLD: if (!ctl_evt) begin
        tmr_restart = 1'b1; tmr_period = lo_cnt;
        if (ctl_sto) begin
          st_n = S_P1; sd_n = 1'b1;
        end else begin
          st_n = S_BLO; idx_n = '0; rx_n = begin_rx; ak_n = ctl_aa;
          if (addr_ph) rm_n = dat_q[0];
          sh_n = begin_rx ? 8'h00 : dat_q;
          sd_n = begin_rx ? 1'b0 : !dat_q[7];
        end
      end
      S_BLO: if (tmr_expire) begin
        st_n = S_BHI; tmr_restart = 1'b1;
      end
      S_BHI: if (tmr_expire) begin
        if (arb_lost) begin
          st_n = S_IDLE; sd_n = 1'b0;
          evt_raise = 1'b1; stat_wr = 1'b1; stat_code = ST_ARB;
        end else if (idx < ACK_SLOT) begin
          sh_n = {shift[6:0], sda_i}; idx_n = idx + 4'd1;
          st_n = S_BLO; tmr_restart = 1'b1; tmr_period = lo_cnt;
          sd_n = (idx == LAST_DATA) ? (rx_now && ack_drv) : (!rx_now && !shift[6]);
        end else begin
          st_n = S_HOLD; evt_raise = 1'b1; stat_wr = 1'b1;
          stat_code = byte_status(addr_ph, rd_mode, ack_seen);
          rx_wr = rx_now; ap_n = 1'b0;
        end
      end
      S_P1: if (tmr_expire) begin
        st_n = S_P2; tmr_restart = 1'b1;
      end
      S_P2: if (tmr_expire) begin
        st_n = S_P3; sd_n = 1'b0; tmr_restart = 1'b1;
      end
      S_P3: if (tmr_expire) begin
        st_n = S_IDLE; sto_done = 1'b1; stat_wr = 1'b1; stat_code = ST_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
    if (!ctl_en && st != S_IDLE) begin
      st_n = S_IDLE; sd_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; shift <= '0; sda_drv <= 1'b0;
      addr_ph <= 1'b0; rd_mode <= 1'b0; rx_now <= 1'b0; ack_drv <= 1'b0;
    end else begin
      st <= st_n; idx <= idx_n; shift <= sh_n; sda_drv <= sd_n;
      addr_ph <= ap_n; rd_mode <= rm_n; rx_now <= rx_n; ack_drv <= ak_n;
    end
  end

  // R4
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && ctl_evt && ctl_en) |=> (st == S_HOLD && scl_oe));
  // R6
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BHI && $past(st) == S_BHI) |-> $stable(sda_oe));
  // R10
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> (!scl_oe && !sda_oe));
  // R11
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && ctl_sto) |=> (st == S_IDLE));
endmodule

// File: rtl/i2cm_status_master.sv
module i2cm_status_master import i2cm_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          dat_we,
  input  logic [7:0]    wdata,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic [7:0]    ctl_q,
  output logic [7:0]    stat_q,
  output logic [7:0]    dat_q,
  output logic          scl_oe,
  output logic          sda_oe
);
  logic          en_q, sta_q, sto_q, evt_q, aa_q;
  logic          evt_raise, stat_wr, sto_done, rx_wr;
  logic [7:0]    stat_code, rx_byte;
  logic          tmr_restart, tmr_expire, bus_free;
  logic [CW-1:0] tmr_period;

  assign bus_free = scl_i && sda_i;

  i2cm_ctl_regs u_regs (
    .clk, .rst_n, .set_we, .clr_we, .dat_we, .wdata,
    .evt_raise, .stat_wr, .stat_code, .sto_done, .rx_wr, .rx_byte,
    .en_q, .sta_q, .sto_q, .evt_q, .aa_q, .ctl_q, .stat_q, .dat_q
  );

  i2cm_phase_timer #(.CW(CW)) u_timer (
    .clk, .rst_n, .restart(tmr_restart), .period(tmr_period), .expire(tmr_expire)
  );

  i2cm_engine #(.CW(CW)) u_engine (
    .clk, .rst_n,
    .ctl_en(en_q), .ctl_sta(sta_q), .ctl_sto(sto_q), .ctl_evt(evt_q), .ctl_aa(aa_q),
    .dat_q, .hi_cnt, .lo_cnt, .bus_free, .sda_i, .tmr_expire,
    .tmr_restart, .tmr_period, .evt_raise, .stat_wr, .stat_code,
    .sto_done, .rx_wr, .rx_byte, .scl_oe, .sda_oe
  );

  // R1
  reset_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !$past(en_q)) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2cm_status_master_test.sv
module i2cm_status_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic set_we = 0, clr_we = 0, dat_we = 0;
  logic [7:0] wdata = 8'h00;
  logic [CW-1:0] hi_cnt = 8'd6, lo_cnt = 8'd4;
  wire  [7:0] ctl_q, stat_q, dat_q;
  wire  scl_oe, sda_oe;
  logic slv_low = 1'b0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | slv_low);

  i2cm_status_master #(.CW(CW)) uut (
    .clk, .rst_n, .set_we, .clr_we, .dat_we, .wdata, .hi_cnt, .lo_cnt,
    .scl_i(scl_line), .sda_i(sda_line),
    .ctl_q, .stat_q, .dat_q, .scl_oe, .sda_oe
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- target model ----------------
  bit addr_ack = 1, data_ack = 1, arb_en = 0;
  int arb_bit = 1;
  logic [7:0] rd_byte = 8'h00;
  logic mack = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  logic ps = 1, pd = 1, active = 0, fresh = 0, rdm = 0, arb_lat = 0;
  int bpos = 0, bcnt = 0;
  logic [7:0] sr = 0;

  always @(negedge clk) begin
    logic cs, cd;
    cs = scl_line; cd = sda_line;
    if (ps && cs && pd && !cd) begin
      active = 1; fresh = 1; bpos = 0; bcnt = 0; rdm = 0;
    end else if (ps && cs && !pd && cd) begin
      active = 0;
    end else if (active) begin
      if (!ps && cs) begin
        if (bpos < 8) begin
          sr = {sr[6:0], cd};
          if (bpos == 7 && (bcnt == 0 || !rdm)) begin
            got_q.push_back(sr);
            if (bcnt == 0) rdm = sr[0];
          end
        end else if (rdm && bcnt > 0) mack = !cd;
      end else if (ps && !cs) begin
        if (fresh) fresh = 0;
        else if (bpos == 8) begin bpos = 0; bcnt++; end
        else bpos++;
      end
    end
    ps = cs; pd = cd;
    if (!arb_en) arb_lat = 0;
    else if (active && bcnt == 0 && bpos == arb_bit && !fresh) arb_lat = 1;
    if (arb_lat) slv_low = 1;
    else if (!active || fresh) slv_low = 0;
    else if (bpos == 8 && bcnt == 0) slv_low = addr_ack;
    else if (bpos == 8 && !rdm) slv_low = data_ack;
    else if (rdm && bcnt > 0 && bpos < 8) slv_low = !rd_byte[7-bpos];
    else slv_low = 0;
  end

  // scoreboard monitor: bytes seen on the wire vs bytes the driver queued (R5, R8)
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) begin
      logic [7:0] g;
      g = got_q.pop_front();
      if (exp_q.size() == 0) chk_eq("R5 unexpected byte on bus", g, 0);
      else chk_eq("R5/R8 byte on bus", g, exp_q.pop_front());
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr_set(input logic [7:0] v);
    @(negedge clk); set_we = 1; wdata = v; @(negedge clk); set_we = 0; wdata = 0;
  endtask
  task automatic wr_clr(input logic [7:0] v);
    @(negedge clk); clr_we = 1; wdata = v; @(negedge clk); clr_we = 0; wdata = 0;
  endtask
  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1; wdata = v; @(negedge clk); dat_we = 0; wdata = 0;
  endtask
  task automatic wait_evt();
    while (!ctl_q[3]) @(negedge clk);
  endtask
  // queue the byte, load it and release the held bus
  task automatic send_byte(input logic [7:0] b, input logic [7:0] clr_bits);
    exp_q.push_back(b);
    wr_dat(b);
    wr_clr(clr_bits);
    wait_evt();
  endtask
  task automatic do_start(input int hold_exp);
    int n;
    wr_set(8'h20);
    while (!sda_oe) @(negedge clk);
    n = 0;
    while (!scl_oe) begin n++; @(negedge clk); end
    chk_eq("R6 start hold cycles", n, hold_exp);
    wait_evt();
    chk_eq("R3 status after START", stat_q, 8'h08);
  endtask
  task automatic do_stop(input int setup_exp);
    int n;
    wr_set(8'h10);
    wr_clr(8'h08);
    while (scl_oe) @(negedge clk);
    n = 0;
    while (!scl_oe && sda_oe) begin n++; @(negedge clk); end
    chk_eq("R6 stop setup cycles", n, setup_exp);
    while (ctl_q[4]) @(negedge clk);
    chk_eq("R7 status after STOP", stat_q, 8'hF8);
    chk_eq("R7 lines released", {30'd0, scl_oe, sda_oe}, 0);
  endtask

  task automatic finish_run();
    chk_eq("R5 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1 control after reset", ctl_q, 8'h00);
    chk_eq("R1 status after reset", stat_q, 8'hF8);
    chk_eq("R1 lines after reset", {30'd0, scl_oe, sda_oe}, 0);

    // R2 set/clear behaviour
    wr_set(8'h44);
    chk_eq("R2 set enable+ack", ctl_q, 8'h44);
    wr_set(8'h00);
    chk_eq("R2 zero set no effect", ctl_q, 8'h44);
    wr_clr(8'h00);
    chk_eq("R2 zero clear no effect", ctl_q, 8'h44);
    wr_set(8'h08);
    chk_eq("R2 event not settable", ctl_q, 8'h44);

    // R11 stop while idle
    wr_set(8'h10);
    repeat (3) @(negedge clk);
    chk_eq("R11 idle stop cleared", ctl_q[4], 0);
    chk_eq("R11 no bus action", {30'd0, scl_oe, sda_oe}, 0);

    // write transfer
    do_start(6);
    repeat (20) @(negedge clk);
    chk_eq("R4 SCL held during event", scl_oe, 1);
    chk_eq("R4 event still set", ctl_q[3], 1);
    send_byte(8'hA0, 8'h28);
    chk_eq("R5 write address ACK", stat_q, 8'h18);
    send_byte(8'h3C, 8'h08);
    chk_eq("R8 data ACK", stat_q, 8'h28);
    data_ack = 0;
    send_byte(8'hC3, 8'h08);
    chk_eq("R8 data NACK", stat_q, 8'h30);
    data_ack = 1;
    wr_set(8'h10);
    wr_clr(8'h10);
    chk_eq("R2 stop not clearable", ctl_q[4], 1);
    do_stop(6);

    // address NACK, new timing
    hi_cnt = 8'd3; lo_cnt = 8'd5;
    addr_ack = 0;
    do_start(3);
    send_byte(8'hB4, 8'h28);
    chk_eq("R5 write address NACK", stat_q, 8'h20);
    addr_ack = 1;
    do_stop(3);

    // read transfer
    hi_cnt = 8'd0;
    do_start(1);
    hi_cnt = 8'd4;
    send_byte(8'hA1, 8'h28);
    chk_eq("R5 read address ACK", stat_q, 8'h40);
    rd_byte = 8'h5A;
    wr_clr(8'h08);
    wait_evt();
    chk_eq("R9 read ACK status", stat_q, 8'h50);
    chk_eq("R9 read byte", dat_q, 8'h5A);
    chk_eq("R9 master ACK driven", mack, 1);
    rd_byte = 8'h96;
    wr_clr(8'h0C);
    wait_evt();
    chk_eq("R9 read NACK status", stat_q, 8'h58);
    chk_eq("R9 second read byte", dat_q, 8'h96);
    chk_eq("R9 master NACK driven", mack, 0);
    do_stop(4);
    wr_set(8'h04);

    // arbitration loss on address bit 6 (a 1 sent by the master)
    do_start(4);
    arb_en = 1; arb_bit = 1;
    wr_dat(8'hFE);
    wr_clr(8'h28);
    wait_evt();
    chk_eq("R10 arbitration status", stat_q, 8'h38);
    chk_eq("R10 lines released", {30'd0, scl_oe, sda_oe}, 0);
    arb_en = 0;
    repeat (4) @(negedge clk);
    wr_clr(8'h28);
    repeat (30) @(negedge clk);
    chk_eq("R10 stays idle", {30'd0, scl_oe, sda_oe}, 0);
    chk_eq("R10 control after recovery", ctl_q, 8'h44);

    done = 1;
    finish_run();
  end
endmodule